// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This block turns a raw CAN receive line into a stream of sampled bits for a CAN controller. A programmable divider makes time-quantum ticks from the input clock. A segment sequencer then walks each bit through a one-quantum sync segment, a first phase that ends at the sample point, and a second phase that ends the bit. Falling edges (recessive to dominant) on the synchronized line are used to re-align the sequencer. When the bus is idle, an edge restarts the bit outright. Otherwise the bit is stretched or cut by at most the jump width.

At each sample point the line is read once, or as a two-of-three vote over the last three quantum ticks. The result is presented on `rx_bit_o` together with a one-clock `sample_o` strobe. A one-clock `bit_start_o` strobe marks the start of each sync segment. The configuration is taken from a packed 32-bit word, and only while `cfg_mode_i` is high. That mode also holds the divider and the sequencer at rest.

Top module: `can_bit_timer`

## Requirements
- R1: The configuration word holds the divider in bits 9:0, the jump field in 15:14, the first-phase field in 19:16, the second-phase field in 22:20 and the vote enable in bit 23. All other bits are ignored. With no edges on the line, `bit_start_o` pulses every (div+1)*(ph1+ph2+3) clocks.
- R2: `sample_o` pulses (div+1)*(ph1+2) clocks after `bit_start_o`. This is one sync quantum plus ph1+1 quanta.
- R3: While `rst_ni` is low, `rx_bit_o`=1, `sample_o`=0 and `bit_start_o`=0. After reset the fields are div=0, jump=0, ph1=12, ph2=1 and vote=0, which gives a 16-clock bit with the sample 14 clocks after bit start.
- R4: The word is loaded only while `cfg_mode_i`=1. Changing it at any other time has no effect on timing. Both strobes stay low in the clock after any cycle in which `cfg_mode_i` was high.
- R5: A falling edge seen at quantum q of the first phase (q counted from 0) lengthens that phase by min(q+1, jump+1) quanta.
- R6: A falling edge seen at quantum q of the second phase has error e = ph2-q. If e <= jump+1, the next quantum is a sync segment. Otherwise the second phase is cut by jump+1 quanta.
- R7: A falling edge seen in the sync segment changes nothing.
- R8: Only the first falling edge of a bit can resynchronize it. Later edges in the same bit are ignored.
- R9: With `bus_idle_i`=1, a falling edge makes the next quantum a sync segment, and `bit_start_o` pulses. The following bits run at nominal timing.
- R10: With vote=1, the sampled bit is the majority of the synchronized line at the sample tick and the two ticks before it.
- R11: With vote=0, the sampled bit is the synchronized line at the sample tick. `rx_bit_o` changes only in a cycle where `sample_o` is high.
- R12: `sample_o` and `bit_start_o` are single-clock pulses and are never high together.
- R13: Rising edges on the line never re-align the bit.
- R14: `rx_i` passes through a two-flop synchronizer. An edge is seen at the first quantum tick where the synchronized line is 0 after being 1 at the previous tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mode_i | input | 1 | Configuration mode: load word, hold timing at rest |
| timing_word_i | input | 32 | Packed timing configuration |
| bus_idle_i | input | 1 | Bus idle: falling edges hard-synchronize |
| rx_i | input | 1 | Raw receive line, 1 = recessive |
| rx_bit_o | output | 1 | Last sampled bit value |
| sample_o | output | 1 | Sample-point strobe |
| bit_start_o | output | 1 | Sync-segment start strobe |

## Verification
The bench sweeps divider and segment lengths and measures, in clocks, the distance from each bit start to its sample point and to the next bit start. An off-by-one in the plus-one field encodings or in the sync segment shifts these distances.

Resynchronization is driven with edges placed at exact quanta:
- Edges in the first phase are checked below and at the jump cap, where a design that ignores the cap would over-stretch the bit.
- Edges in the second phase are checked on both sides of the early-end boundary, where a design that confuses e with the cap would end the bit one quantum off.
- A second edge in the same bit tests the one-per-bit rule.
- An edge in the sync segment and a rising edge test that neither re-aligns the bit.

Glitch patterns at the sample point separate majority voting from single sampling. A wrong vote window flips the reported bit.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned BRP_W   = 10;
  localparam int unsigned SJW_W   = 2;
  localparam int unsigned TS1_W   = 4;
  localparam int unsigned TS2_W   = 3;
  localparam int unsigned BRP_LSB = 0;
  localparam int unsigned SJW_LSB = 14;
  localparam int unsigned TS1_LSB = 16;
  localparam int unsigned TS2_LSB = 20;
  localparam int unsigned SAM_BIT = 23;

  typedef struct packed {
    logic [BRP_W-1:0] div;
    logic [SJW_W-1:0] jump;
    logic [TS1_W-1:0] ph1;
    logic [TS2_W-1:0] ph2;
    logic             vote;
  } bt_cfg_t;

  localparam bt_cfg_t BT_CFG_RST = '{
    div:  '0,
    jump: '0,
    ph1:  TS1_W'(12),
    ph2:  TS2_W'(1),
    vote: 1'b0
  };

  typedef enum logic [1:0] {SEG_SYNC, SEG_PH1, SEG_PH2} bt_seg_e;

  function automatic bt_cfg_t bt_unpack(input logic [WORD_W-1:0] w);
    bt_cfg_t c;
    c.div  = w[BRP_LSB +: BRP_W];
    c.jump = w[SJW_LSB +: SJW_W];
    c.ph1  = w[TS1_LSB +: TS1_W];
    c.ph2  = w[TS2_LSB +: TS2_W];
    c.vote = w[SAM_BIT];
    return c;
  endfunction
endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg
  import can_bt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output bt_cfg_t           cfg_o
);
  bt_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= BT_CFG_RST;
    else if (load_i) cfg_q <= bt_unpack(word_i);
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int unsigned DIV_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (hold_i) cnt_q <= '0;
    else if (wrap)   cnt_q <= '0;
    else             cnt_q <= cnt_q + DIV_W'(1);
  end

  assign tick_o = wrap & ~hold_i;
endmodule

// File: rtl/can_bt_rx_front.sv
module can_bt_rx_front #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic tick_i,
  input  logic rx_i,
  input  logic vote_i,
  output logic fall_o,
  output logic bit_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  logic                   prev_q;
  logic [1:0]             hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
  end

  assign rx_s = sync_q[SYNC_STAGES-1];

  // line value at previous quantum ticks; recessive while held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      hist_q <= 2'b11;
    end else if (hold_i) begin
      prev_q <= 1'b1;
      hist_q <= 2'b11;
    end else if (tick_i) begin
      prev_q <= rx_s;
      hist_q <= {hist_q[0], rx_s};
    end
  end

  assign fall_o = tick_i & prev_q & ~rx_s;
  assign bit_o  = vote_i ? ((hist_q[1] & hist_q[0]) | (hist_q[1] & rx_s) | (hist_q[0] & rx_s))
                         : rx_s;
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int unsigned JW  = 2,
  parameter int unsigned T1W = 4,
  parameter int unsigned T2W = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           hold_i,
  input  logic           tick_i,
  input  logic           fall_i,
  input  logic           hard_en_i,
  input  logic           bit_i,
  input  logic [JW-1:0]  jump_i,
  input  logic [T1W-1:0] ph1_i,
  input  logic [T2W-1:0] ph2_i,
  output logic           rx_bit_o,
  output logic           sample_o,
  output logic           bit_start_o
);
  localparam int unsigned QW = ((T1W > T2W) ? T1W : T2W) + 2;
  localparam int unsigned EW = JW + 1;

  bt_seg_e       seg_q, seg_d;
  logic [QW-1:0] qcnt_q, qcnt_d;
  logic [EW-1:0] ext_q, ext_d, cut_q, cut_d;
  logic          done_q, done_d;
  logic          bit_q, bit_d, samp_q, samp_d, bs_q, bs_d;
  logic          new_bit;

  logic [QW-1:0] jump_q, ph1_last, ph2_last, err1, err2;

  assign jump_q   = QW'(jump_i) + QW'(1);
  assign ph1_last = QW'(ph1_i) + QW'(ext_q);
  assign ph2_last = QW'(ph2_i) - QW'(cut_q);
  assign err1     = qcnt_q + QW'(1);
  assign err2     = QW'(ph2_i) - qcnt_q;

  always_comb begin
    seg_d   = seg_q;
    qcnt_d  = qcnt_q;
    ext_d   = ext_q;
    cut_d   = cut_q;
    done_d  = done_q;
    bit_d   = bit_q;
    samp_d  = 1'b0;
    bs_d    = 1'b0;
    new_bit = 1'b0;
    if (hold_i) begin
      seg_d  = SEG_SYNC;
      qcnt_d = '0;
      ext_d  = '0;
      cut_d  = '0;
      done_d = 1'b0;
    end else if (tick_i) begin
      if (fall_i && hard_en_i) begin
        new_bit = 1'b1;
      end else begin
        case (seg_q)
          SEG_SYNC: begin
            seg_d  = SEG_PH1;
            qcnt_d = '0;
          end
          SEG_PH1: begin
            if (fall_i && !done_q) begin
              // late edge: stretch phase 1, capped at jump width
              ext_d  = EW'((err1 < jump_q) ? err1 : jump_q);
              done_d = 1'b1;
              qcnt_d = qcnt_q + QW'(1);
            end else if (qcnt_q == ph1_last) begin
              samp_d = 1'b1;
              bit_d  = bit_i;
              seg_d  = SEG_PH2;
              qcnt_d = '0;
            end else begin
              qcnt_d = qcnt_q + QW'(1);
            end
          end
          SEG_PH2: begin
            if (fall_i && !done_q) begin
              // early edge: restart now if within reach, else cut by jump
              if (err2 <= jump_q) begin
                new_bit = 1'b1;
              end else begin
                cut_d  = EW'(jump_q);
                done_d = 1'b1;
                qcnt_d = qcnt_q + QW'(1);
              end
            end else if (qcnt_q == ph2_last) begin
              new_bit = 1'b1;
            end else begin
              qcnt_d = qcnt_q + QW'(1);
            end
          end
          default: seg_d = SEG_SYNC;
        endcase
      end
      if (new_bit) begin
        seg_d  = SEG_SYNC;
        qcnt_d = '0;
        ext_d  = '0;
        cut_d  = '0;
        done_d = 1'b0;
        bs_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q  <= SEG_SYNC;
      qcnt_q <= '0;
      ext_q  <= '0;
      cut_q  <= '0;
      done_q <= 1'b0;
      bit_q  <= 1'b1;
      samp_q <= 1'b0;
      bs_q   <= 1'b0;
    end else begin
      seg_q  <= seg_d;
      qcnt_q <= qcnt_d;
      ext_q  <= ext_d;
      cut_q  <= cut_d;
      done_q <= done_d;
      bit_q  <= bit_d;
      samp_q <= samp_d;
      bs_q   <= bs_d;
    end
  end

  assign rx_bit_o    = bit_q;
  assign sample_o    = samp_q;
  assign bit_start_o = bs_q;
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_mode_i,
  input  logic [WORD_W-1:0] timing_word_i,
  input  logic              bus_idle_i,
  input  logic              rx_i,
  output logic              rx_bit_o,
  output logic              sample_o,
  output logic              bit_start_o
);
  bt_cfg_t cfg;
  logic    tick, fall, voted;

  can_bt_cfg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cfg_mode_i),
    .word_i (timing_word_i),
    .cfg_o  (cfg)
  );

  can_bt_prescaler #(.DIV_W(BRP_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (cfg_mode_i),
    .div_i  (cfg.div),
    .tick_o (tick)
  );

  can_bt_rx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (cfg_mode_i),
    .tick_i (tick),
    .rx_i   (rx_i),
    .vote_i (cfg.vote),
    .fall_o (fall),
    .bit_o  (voted)
  );

  can_bt_seq #(.JW(SJW_W), .T1W(TS1_W), .T2W(TS2_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_i      (cfg_mode_i),
    .tick_i      (tick),
    .fall_i      (fall),
    .hard_en_i   (bus_idle_i),
    .bit_i       (voted),
    .jump_i      (cfg.jump),
    .ph1_i       (cfg.ph1),
    .ph2_i       (cfg.ph2),
    .rx_bit_o    (rx_bit_o),
    .sample_o    (sample_o),
    .bit_start_o (bit_start_o)
  );
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_mode_i,
  input logic rx_bit_o,
  input logic sample_o,
  input logic bit_start_o
);
  // R12
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_o && bit_start_o));

  // R12
  sample_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);

  // R12
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_start_o |=> !bit_start_o);

  // R11
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_bit_o != $past(rx_bit_o)) |-> sample_o);

  // R4
  cfg_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_mode_i) |-> (!sample_o && !bit_start_o));
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_mode_i  (cfg_mode_i),
  .rx_bit_o    (rx_bit_o),
  .sample_o    (sample_o),
  .bit_start_o (bit_start_o)
);

// File: tb/tb_can_bit_timer.sv
module tb_can_bit_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_mode = 1'b0;
  logic        idle = 1'b0;
  logic        rx = 1'b1;
  logic [31:0] tword = '0;
  logic        rx_bit, samp, bs;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_bit_timer dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .cfg_mode_i    (cfg_mode),
    .timing_word_i (tword),
    .bus_idle_i    (idle),
    .rx_i          (rx),
    .rx_bit_o      (rx_bit),
    .sample_o      (samp),
    .bit_start_o   (bs)
  );

  function automatic logic [31:0] mk(int dv, int jw, int t1, int t2, int vt);
    logic [31:0] w = '0;
    w[9:0]   = dv[9:0];
    w[15:14] = jw[1:0];
    w[19:16] = t1[3:0];
    w[22:20] = t2[2:0];
    w[23]    = vt[0];
    return w;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic configure(input logic [31:0] w);
    @(negedge clk);
    cfg_mode = 1'b1;
    tword = w;
    repeat (2) @(negedge clk);
    cfg_mode = 1'b0;
  endtask

  task automatic sync_bs();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!bs && n < 5000);
    if (!bs) chk("R1 bit start seen", 0, 1);
  endtask

  // starts at a negedge showing bit_start (j=0); events drive rx at negedge j
  task automatic run_bit(input int dj[4], input logic dv[4],
                         output int sj, output int bj, output logic sb);
    sj = -1;
    bj = -1;
    sb = 1'b0;
    for (int j = 0; j < 3000; j++) begin
      for (int k = 0; k < 4; k++) if (dj[k] == j) rx = dv[k];
      @(negedge clk);
      if (samp && sj < 0) begin
        sj = j + 1;
        sb = rx_bit;
      end
      if (bs) begin
        bj = j + 1;
        break;
      end
    end
  endtask

  task automatic clean(output int sj, output int bj);
    logic b;
    run_bit('{-1, -1, -1, -1}, '{1'b1, 1'b1, 1'b1, 1'b1}, sj, bj, b);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int sj, bj;
    logic b;
    int t1s[4] = '{0, 3, 12, 15};
    int t2s[3] = '{0, 1, 7};

    repeat (3) @(negedge clk);
    chk("R3 reset rx_bit", int'(rx_bit), 1);
    chk("R3 reset sample", int'(samp), 0);
    chk("R3 reset bit_start", int'(bs), 0);
    rst_n = 1'b1;

    sync_bs();
    clean(sj, bj);
    chk("R3 default sample offset", sj, 14);
    chk("R3 default bit period", bj, 16);

    for (int d = 0; d < 3; d++)
      for (int a = 0; a < 4; a++)
        for (int c = 0; c < 3; c++) begin
          configure(mk(d, 0, t1s[a], t2s[c], 0));
          sync_bs();
          clean(sj, bj);
          chk("R2 sample offset", sj, (d + 1) * (t1s[a] + 2));
          chk("R1 bit period", bj, (d + 1) * (t1s[a] + t2s[c] + 3));
        end

    configure(mk(1, 0, 3, 2, 0) | 32'hFF00_3C00);
    sync_bs();
    clean(sj, bj);
    chk("R1 reserved bits sample", sj, 10);
    chk("R1 reserved bits period", bj, 16);

    // ph1=5 ph2=5 jump=1 (cap 2): nominal sample 7, period 13
    configure(mk(0, 1, 5, 5, 0));
    sync_bs();
    tword = mk(2, 0, 1, 1, 0);
    clean(sj, bj);
    chk("R4 word ignored outside cfg sample", sj, 7);
    chk("R4 word ignored outside cfg period", bj, 13);

    // R5/R14: drop at j=0 -> edge at phase-1 quantum 1, e=2, cap 2
    run_bit('{0, 1, -1, -1}, '{1'b0, 1'b1, 1'b1, 1'b1}, sj, bj, b);
    chk("R5 stretch sample", sj, 9);
    chk("R5 stretch period", bj, 15);
    clean(sj, bj);

    // R6: phase-2 edges (drop at j = 5+q)
    run_bit('{9, 10, -1, -1}, '{1'b0, 1'b1, 1'b1, 1'b1}, sj, bj, b);
    chk("R6 e=1 restart", bj, 12);
    clean(sj, bj);
    run_bit('{8, 9, -1, -1}, '{1'b0, 1'b1, 1'b1, 1'b1}, sj, bj, b);
    chk("R6 e=cap restart", bj, 11);
    clean(sj, bj);
    run_bit('{7, 8, -1, -1}, '{1'b0, 1'b1, 1'b1, 1'b1}, sj, bj, b);
    chk("R6 e=3 cut by cap", bj, 11);
    clean(sj, bj);
    run_bit('{6, 7, -1, -1}, '{1'b0, 1'b1, 1'b1, 1'b1}, sj, bj, b);
    chk("R6 e=4 cut by cap", bj, 11);
    clean(sj, bj);

    // R8: second edge in same bit ignored
    run_bit('{0, 3, 8, 9}, '{1'b0, 1'b1, 1'b0, 1'b1}, sj, bj, b);
    chk("R8 one resync sample", sj, 9);
    chk("R8 one resync period", bj, 15);
    clean(sj, bj);

    // R7: edge lands in next bit's sync segment
    run_bit('{11, -1, -1, -1}, '{1'b0, 1'b1, 1'b1, 1'b1}, sj, bj, b);
    chk("R7 pre-sync period", bj, 13);
    run_bit('{3, -1, -1, -1}, '{1'b1, 1'b1, 1'b1, 1'b1}, sj, bj, b);
    chk("R7 sync edge sample", sj, 7);
    chk("R13 rising edge period", bj, 13);
    clean(sj, bj);

    // R5 cap with jump=0, and below cap with jump=3
    configure(mk(0, 0, 5, 5, 0));
    sync_bs();
    clean(sj, bj);
    run_bit('{2, 3, -1, -1}, '{1'b0, 1'b1, 1'b1, 1'b1}, sj, bj, b);
    chk("R5 cap jump0 sample", sj, 8);
    chk("R5 cap jump0 period", bj, 14);
    configure(mk(0, 3, 5, 5, 0));
    sync_bs();
    clean(sj, bj);
    run_bit('{0, 1, -1, -1}, '{1'b0, 1'b1, 1'b1, 1'b1}, sj, bj, b);
    chk("R5 under cap sample", sj, 9);

    // R9: hard sync while idle
    configure(mk(0, 1, 5, 5, 0));
    sync_bs();
    clean(sj, bj);
    idle = 1'b1;
    run_bit('{2, 3, -1, -1}, '{1'b0, 1'b1, 1'b1, 1'b1}, sj, bj, b);
    chk("R9 hard sync in phase 1", bj, 5);
    clean(sj, bj);
    chk("R9 after hard sync sample", sj, 7);
    chk("R9 after hard sync period", bj, 13);
    run_bit('{7, 8, -1, -1}, '{1'b0, 1'b1, 1'b1, 1'b1}, sj, bj, b);
    chk("R9 hard sync in phase 2", bj, 10);
    idle = 1'b0;
    clean(sj, bj);

    // R10: vote on; sample ticks map to drives j=4,5,6
    configure(mk(0, 1, 5, 5, 1));
    sync_bs();
    clean(sj, bj);
    run_bit('{0, 1, 6, 7}, '{1'b0, 1'b1, 1'b0, 1'b1}, sj, bj, b);
    chk("R10 lone dominant rejected", int'(b), 1);
    chk("R10 sample offset", sj, 9);
    run_bit('{0, 1, 4, 6}, '{1'b0, 1'b1, 1'b0, 1'b1}, sj, bj, b);
    chk("R10 two dominant win", int'(b), 0);

    // R11: single sample, same patterns
    configure(mk(0, 1, 5, 5, 0));
    sync_bs();
    clean(sj, bj);
    run_bit('{0, 1, 6, 7}, '{1'b0, 1'b1, 1'b0, 1'b1}, sj, bj, b);
    chk("R11 single sample dominant", int'(b), 0);
    run_bit('{0, 1, 4, 6}, '{1'b0, 1'b1, 1'b0, 1'b1}, sj, bj, b);
    chk("R11 single sample recessive", int'(b), 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule